// File: doc/BRIEF.md
# I2C Eight-Bit Port Expander Core

This block is an I2C target that gives a controller access to an 8-bit bidirectional port through four byte-wide registers: the input levels, the output latch, a per-bit read polarity mask and a per-bit direction mask. The first data byte of a write transaction is a command byte. Its low two bits select a register, and any later bytes in the same transaction are written to that register. A read transaction returns the register chosen by the last command byte.

The 7-bit target address has two parts. The upper four bits are a fixed pattern picked by the `VARIANT` parameter, and the lower three bits come from strap inputs. SCL, SDA and the port pins are all sampled with the system clock through synchronizers. SDA is driven open-drain: `sda_oe` high means "pull the line low". Each pin's output enable comes from the direction register. Clock stretching, interrupt signalling and 10-bit addressing are not part of this block.

Top module: `gx_port_expander`

## Requirements
- R1: The address byte is {pattern[3:0], strap_a[2:0], rw}, with MSB first and rw=1 meaning read. The pattern is 4'b0100 when VARIANT=0 and 4'b0111 when VARIANT=1. The target ACKs only an exact match. On a mismatch it never drives SDA and ignores all bytes until the next START.
- R2: Register 0 (input) reads as the synchronized pin levels XOR the polarity register, whatever each pin's direction. Writes to it are ACKed and change no register.
- R3: Register 1 (output latch) resets to 0xFF. A write to it appears on `pin_o`.
- R4: A read of register 1 returns the latch value, even when the pin levels differ from it.
- R5: Register 2 (polarity) resets to 0x00. A 1 in bit n inverts bit n of register-0 reads, and a 0 keeps the true level.
- R6: Register 3 (direction) resets to 0xFF. `pin_oe[n]` is the inverse of bit n, so 1 makes the pin an input.
- R7: The first data byte after a write address is the command, and its bits [1:0] select the register. Every further byte of that transaction writes the same register, and the pointer does not advance.
- R8: A read returns the register selected by the last command byte, MSB first, with bit n equal to port bit n. Every byte of a multi-byte read comes from the same register.
- R9: SDA changes only while SCL is low. The target ACKs every written byte. It releases SDA after each byte it sends, and it stops sending when the controller NACKs.
- R10: A START or repeated START restarts address reception from any state, including in the middle of a byte. A STOP returns the block to idle with SDA released.
- R11: For a register-0 read, the value is captured at the start of the address ACK clock. Pin changes after that point do not alter the byte being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_a | input | 3 | Address strap bits, placed at address bits 2..0 |
| pin_i | input | 8 | Port pin levels |
| pin_o | output | 8 | Output latch driven toward the pins |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |

## Verification
The embedded properties check several things on every cycle. SDA is only ever pulled or released while the sampled SCL is low. Idle and STOP always leave SDA released. A data write to the output or direction register reaches `pin_o` or `pin_oe` on the next cycle. A write aimed at the input register leaves all pin-facing state untouched. Other behaviours can only be shown by the bench's controller scenarios: address match and mismatch for both the pattern and the straps, the polarity-adjusted input values, latch readback while the pins disagree, pointer persistence over multi-byte transfers, capture timing, and recovery from a START in the middle of a byte.

// File: rtl/gx_pkg.sv
package gx_pkg;
   localparam int DATA_W    = 8;
   localparam int ADDR_W    = 7;
   localparam int STRAP_W   = 3;
   localparam int FIXED_W   = ADDR_W - STRAP_W;
   localparam int REG_SEL_W = 2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
   } gx_state_e;

   typedef enum logic [REG_SEL_W-1:0] {
      RG_IN  = 2'd0,
      RG_OUT = 2'd1,
      RG_POL = 2'd2,
      RG_DIR = 2'd3
   } gx_reg_e;
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gx_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/gx_i2c_engine.sv
module gx_i2c_engine
   import gx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_stb,
   output logic              wr_cmd,
   output logic [DATA_W-1:0] wr_data,
   output logic              sda_oe
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   gx_state_e         st;
   logic              scl_q, sda_q;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic              rw, first, nack;

   wire scl_rise = scl_s & ~scl_q;
   wire scl_fall = ~scl_s & scl_q;
   wire start    = scl_s & scl_q & sda_q & ~sda_s;
   wire stop     = scl_s & scl_q & ~sda_q & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         st      <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         rw      <= 1'b0;
         first   <= 1'b0;
         nack    <= 1'b0;
         sda_oe  <= 1'b0;
         wr_stb  <= 1'b0;
         wr_cmd  <= 1'b0;
         wr_data <= '0;
      end else begin
         scl_q  <= scl_s;
         sda_q  <= sda_s;
         wr_stb <= 1'b0;
         if (start) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR, ST_WBYTE: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     sh  <= {sh[DATA_W-2:0], sda_s};
                     cnt <= cnt + CNT_W'(1);
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     if (st == ST_ADDR) begin
                        if (sh[DATA_W-1:1] == dev_addr) begin
                           st     <= ST_AACK;
                           sda_oe <= 1'b1;
                           rw     <= sh[0];
                           sh     <= rd_data;   // capture for a read
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        st      <= ST_WACK;
                        sda_oe  <= 1'b1;
                        wr_stb  <= 1'b1;
                        wr_cmd  <= first;
                        wr_data <= sh;
                        first   <= 1'b0;
                     end
                  end
               end
               ST_AACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     st     <= ST_RBYTE;
                     sda_oe <= ~sh[DATA_W-1];
                  end else begin
                     st     <= ST_WBYTE;
                     sda_oe <= 1'b0;
                     first  <= 1'b1;
                  end
               end
               ST_WACK: if (scl_fall) begin
                  st     <= ST_WBYTE;
                  sda_oe <= 1'b0;
                  cnt    <= '0;
               end
               ST_RBYTE: if (scl_fall) begin
                  if (cnt == CNT_LAST) begin
                     st     <= ST_RACK;
                     sda_oe <= 1'b0;
                  end else begin
                     cnt    <= cnt + CNT_W'(1);
                     sh     <= {sh[DATA_W-2:0], 1'b0};
                     sda_oe <= ~sh[DATA_W-2];
                  end
               end
               ST_RACK: begin
                  if (scl_rise) nack <= sda_s;
                  if (scl_fall) begin
                     if (nack) begin
                        st <= ST_IDLE;
                     end else begin
                        st     <= ST_RBYTE;
                        cnt    <= '0;
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R9: SDA is only ever pulled or released while SCL was sampled low
   p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_q);

   // R1: nothing is driven while idle (mismatch or after NACK)
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R10: a STOP leaves the engine idle with SDA released
   p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (st == ST_IDLE && !sda_oe));
endmodule

// File: rtl/gx_regfile.sv
module gx_regfile
   import gx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              wr_cmd,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] pin_s,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] pin_o,
   output logic [DATA_W-1:0] pin_oe
);
   gx_reg_e           ptr;
   logic [DATA_W-1:0] out_r, pol_r, dir_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= RG_IN;
         out_r <= '1;
         pol_r <= '0;
         dir_r <= '1;
      end else if (wr_stb) begin
         if (wr_cmd) begin
            ptr <= gx_reg_e'(wr_data[REG_SEL_W-1:0]);
         end else begin
            unique case (ptr)
               RG_OUT:  out_r <= wr_data;
               RG_POL:  pol_r <= wr_data;
               RG_DIR:  dir_r <= wr_data;
               default: ;   // input register is read-only
            endcase
         end
      end
   end

   always_comb begin
      unique case (ptr)
         RG_IN:   rd_data = pin_s ^ pol_r;
         RG_OUT:  rd_data = out_r;
         RG_POL:  rd_data = pol_r;
         default: rd_data = dir_r;
      endcase
   end

   assign pin_o  = out_r;
   assign pin_oe = ~dir_r;

   // R3: a data write to the output latch reaches the pins next cycle
   p_out_to_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_cmd && ptr == RG_OUT) |=> (pin_o == $past(wr_data)));

   // R6: a data write to the direction register sets the enables next cycle
   p_dir_to_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_cmd && ptr == RG_DIR) |=> (pin_oe == ~$past(wr_data)));

   // R2: writes aimed at the input register change nothing
   p_in_readonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_cmd && ptr == RG_IN) |=>
         ($stable(pin_o) && $stable(pin_oe) && $stable(pol_r)));
endmodule

// File: rtl/gx_port_expander.sv
module gx_port_expander
   import gx_pkg::*;
#(
   parameter int VARIANT     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [STRAP_W-1:0] strap_a,
   input  logic [DATA_W-1:0]  pin_i,
   output logic [DATA_W-1:0]  pin_o,
   output logic [DATA_W-1:0]  pin_oe
);
   logic [FIXED_W-1:0] fixed_hi;
   logic [1:0]         bus_s;
   logic [DATA_W-1:0]  pin_s, rd_data, wr_data;
   logic               wr_stb, wr_cmd;

   if (VARIANT == 0) begin : g_var_a
      assign fixed_hi = 4'b0100;
   end else if (VARIANT == 1) begin : g_var_b
      assign fixed_hi = 4'b0111;
   end else begin : g_var_bad
      assign fixed_hi = '0;
      $error("gx_port_expander: VARIANT must be 0 or 1");
   end

   gx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

   gx_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s));

   gx_i2c_engine u_engine (
      .clk(clk), .rst_n(rst_n),
      .scl_s(bus_s[1]), .sda_s(bus_s[0]),
      .dev_addr({fixed_hi, strap_a}),
      .rd_data(rd_data),
      .wr_stb(wr_stb), .wr_cmd(wr_cmd), .wr_data(wr_data),
      .sda_oe(sda_oe));

   gx_regfile u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_stb), .wr_cmd(wr_cmd), .wr_data(wr_data),
      .pin_s(pin_s), .rd_data(rd_data),
      .pin_o(pin_o), .pin_oe(pin_oe));
endmodule

// File: tb/gx_port_expander_tb.sv
module gx_port_expander_tb;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 10;
   localparam int H = 20;
   localparam logic [7:0] WADDR = 8'h4A;   // 0100_101, write
   localparam logic [7:0] RADDR = 8'h4B;   // 0100_101, read

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [7:0] pin_drv = 8'h00;
   logic sda_oe;
   logic [7:0] pin_o, pin_oe;
   wire sda_line = sda_m & ~sda_oe;

   int checks = 0, errors = 0;
   bit hold = 1'b1, done = 1'b0;
   // behavioural reference model
   logic [1:0] mdl_ptr = 2'd0;
   logic [7:0] mdl_out = 8'hFF, mdl_pol = 8'h00, mdl_dir = 8'hFF;

   always #(CLK_PERIOD/2) clk = ~clk;

   gx_port_expander #(.VARIANT(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .strap_a(3'b101), .pin_i(pin_drv),
      .pin_o(pin_o), .pin_oe(pin_oe));

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-clock comparison of pin-facing outputs against the model (R3, R6, R9)
   always @(negedge clk) begin
      if (rst_n && !hold) begin
         checks++;
         if (pin_o !== mdl_out || pin_oe !== ~mdl_dir || sda_oe !== 1'b0) begin
            errors++;
            $display("FAIL R3/R6/R9 per-clock actual o=%h oe=%h sda=%b expected o=%h oe=%h sda=0",
                     pin_o, pin_oe, sda_oe, mdl_out, ~mdl_dir);
         end
      end
   end

   task automatic i2c_start();
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(Q); scl_m = 1'b1; wq(H); scl_m = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
      ack = ~sda_line;
      wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic recv_byte(input logic nack_i, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0;
      end
      wq(Q); sda_m = nack_i; wq(Q); scl_m = 1'b1; wq(H); scl_m = 1'b0; wq(Q);
      sda_m = 1'b1;
   endtask

   task automatic do_write(input logic [7:0] abyte, input logic [7:0] bytes[$],
                           input logic exp_ack, input string tag);
      logic ack;
      hold = 1'b1;
      i2c_start();
      send_byte(abyte, ack);
      chk({7'd0, ack}, {7'd0, exp_ack}, {tag, " address ack"});
      foreach (bytes[k]) begin
         send_byte(bytes[k], ack);
         chk({7'd0, ack}, {7'd0, exp_ack}, {tag, " R9 data ack"});
         if (exp_ack) begin
            if (k == 0) mdl_ptr = bytes[k][1:0];
            else case (mdl_ptr)
               2'd1: mdl_out = bytes[k];
               2'd2: mdl_pol = bytes[k];
               2'd3: mdl_dir = bytes[k];
               default: ;
            endcase
         end
      end
      i2c_stop();
      wq(4);
      hold = 1'b0;
   endtask

   task automatic set_ptr(input logic [1:0] p);
      do_write(WADDR, '{{6'd0, p}}, 1'b1, "R7 pointer");
   endtask

   task automatic read_expect(input int n, input logic [7:0] exp, input string tag);
      logic ack;
      logic [7:0] b;
      hold = 1'b1;
      i2c_start();
      send_byte(RADDR, ack);
      chk({7'd0, ack}, 8'd1, {tag, " R1 read address ack"});
      for (int k = 0; k < n; k++) begin
         recv_byte(k == n - 1, b);
         chk(b, exp, tag);
      end
      i2c_stop();
      wq(4);
      hold = 1'b0;
   endtask

   initial begin
      logic ack;
      logic [7:0] b;
      wq(5);
      rst_n = 1'b1;
      wq(5);
      // reset state
      chk(pin_o, 8'hFF, "R3 reset output latch");
      chk(pin_oe, 8'h00, "R6 reset enables");
      chk({7'd0, sda_oe}, 8'd0, "R9 reset sda released");
      hold = 1'b0;

      set_ptr(2'd1); read_expect(1, 8'hFF, "R3 output reset readback");
      set_ptr(2'd2); read_expect(1, 8'h00, "R5 polarity reset readback");
      set_ptr(2'd3); read_expect(1, 8'hFF, "R6 direction reset readback");

      // address mismatch: wrong strap bits, and the other variant's pattern
      do_write(8'h4C, '{8'h01, 8'h00}, 1'b0, "R1 strap mismatch");
      do_write(8'h7A, '{8'h01, 8'h00}, 1'b0, "R1 pattern mismatch");
      chk(pin_o, 8'hFF, "R1 mismatched write ignored");

      // input reads and polarity
      pin_drv = 8'h5A; wq(5);
      set_ptr(2'd0); read_expect(1, 8'h5A, "R2 input levels");
      do_write(WADDR, '{8'h02, 8'h0F}, 1'b1, "R5 polarity write");
      set_ptr(2'd0); read_expect(1, 8'h55, "R5 inverted input");

      // input register is read-only
      do_write(WADDR, '{8'h00, 8'h00, 8'hFF}, 1'b1, "R2 write input reg");
      chk(pin_o, 8'hFF, "R2 output untouched");
      set_ptr(2'd2); read_expect(1, 8'h0F, "R2 polarity untouched");

      // direction and output latch
      do_write(WADDR, '{8'h03, 8'hF0}, 1'b1, "R6 direction write");
      chk(pin_oe, 8'h0F, "R6 enables follow direction");
      do_write(WADDR, '{8'h01, 8'h3C}, 1'b1, "R3 output write");
      chk(pin_o, 8'h3C, "R3 output latch on pins");
      pin_drv = 8'hC3; wq(5);
      set_ptr(2'd1); read_expect(1, 8'h3C, "R4 latch not pin readback");
      set_ptr(2'd0); read_expect(1, 8'hCC, "R2 input of output pins");

      // multi-byte write keeps pointer
      do_write(WADDR, '{8'h01, 8'h11, 8'h22}, 1'b1, "R7 multi-byte write");
      chk(pin_o, 8'h22, "R7 last byte to same register");
      set_ptr(2'd3); read_expect(3, 8'hF0, "R8 repeated reads same register");
      chk({7'd0, sda_oe}, 8'd0, "R9 released after NACK");

      // capture at address ACK
      pin_drv = 8'hA5; wq(5);
      set_ptr(2'd0);
      hold = 1'b1;
      i2c_start();
      send_byte(RADDR, ack);
      chk({7'd0, ack}, 8'd1, "R11 read address ack");
      pin_drv = 8'h00;
      recv_byte(1'b1, b);
      chk(b, 8'hAA, "R11 captured input value");
      i2c_stop(); wq(4);
      hold = 1'b0;

      // START in the middle of a byte restarts address reception
      hold = 1'b1;
      i2c_start();
      for (int i = 7; i >= 4; i--) send_bit(WADDR[i]);
      i2c_start();
      send_byte(WADDR, ack);
      chk({7'd0, ack}, 8'd1, "R10 address after restart");
      send_byte(8'h01, ack);
      send_byte(8'h77, ack);
      chk({7'd0, ack}, 8'd1, "R10 data ack after restart");
      i2c_stop(); wq(4);
      mdl_ptr = 2'd1; mdl_out = 8'h77;
      hold = 1'b0;
      chk(pin_o, 8'h77, "R10 write after restart");
      wq(20);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule